// File: doc/BRIEF.md
# Interleaved Circular Acquisition Address Generator

This block produces the write addresses for a four-channel digitizer whose samples go into a byte-addressed memory, one 16-bit sample per write. The four channels share the memory round-robin. A group is one sample from each channel, and the channel with index 0 always sits at the lowest byte of its group. Each write therefore advances the address by 2 bytes. One channel's consecutive samples are 8 bytes apart. The region in use runs from a base address for a set number of bytes, and writing wraps back to the base when it reaches the end.

A shot begins with an arm pulse. Arm latches the base address, the region size, the number of pre-trigger groups and the number of post-trigger groups. The block then emits one write for each sample strobe.

A trigger is honoured only after the pre-trigger count of groups has been written. Once it is honoured, the block writes exactly the post-trigger count of groups. It then pulses done for one cycle and stops writing. The block also keeps the byte address of channel 0's sample in the last pre-trigger group, so software can find the trigger point in the circular buffer.

Top module: `acq_addr_gen`

## Requirements
- R1: After arm, the first write goes to the base address with channel index 0. Each later write adds 2 to the byte address. The channel index steps 0,1,2,3 and then repeats.
- R2: When the next address would equal base plus size, the write goes to the base address instead. The size is a multiple of 8, so every group starts at a byte offset from the base that is a multiple of 8.
- R3: Write enable is high only in a cycle where the sample strobe is high and a shot is active. There are no writes after reset, before arm, or after done.
- R4: A trigger pulse that arrives before the pre-trigger count of groups has been completed has no effect. The pulse is not remembered, and the shot keeps waiting for a later trigger.
- R5: A trigger that arrives at a group boundary, once the pre-trigger count has been reached, makes the current write the first post-trigger write. The trigger position becomes the channel 0 address of the group just before it. If no group has been written yet, the trigger position is base + size - 8.
- R6: A trigger that arrives in the middle of a group lets that group finish as a pre-trigger group. The trigger position then becomes that group's channel 0 address.
- R7: After the trigger takes effect, exactly the post-trigger count of groups is written. Done is high for one cycle, in the cycle after the last write. With a post-trigger count of 0, no write follows the trigger and done rises in the next cycle.
- R8: An arm pulse during an active shot is ignored. The base, size, counts and address sequence all stay unchanged.
- R9: Immediately after reset, write enable is 0, done is 0 and the trigger position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start-of-shot pulse, taken only when idle |
| smp_vld | input | 1 | One sample is ready to be written |
| trig | input | 1 | Trigger pulse |
| pre_cnt | input | CNT_W | Groups required before a trigger is honoured |
| post_cnt | input | CNT_W | Groups written after the trigger |
| buf_base | input | ADDR_W | Byte base address of the region |
| buf_size | input | ADDR_W | Region size in bytes, a nonzero multiple of 8 |
| wr_addr | output | ADDR_W | Byte address of the current write |
| wr_en | output | 1 | Write strobe |
| wr_ch | output | 2 | Channel index of the current write |
| trig_pos | output | ADDR_W | Channel 0 address of the last pre-trigger group |
| done | output | 1 | One-cycle shot-complete pulse |

## Verification
The assertions on address stepping and group alignment assume that the size latched at arm is a nonzero multiple of 8. They also assume that base plus size does not overflow the address width. Every vector in the bench uses such sizes, chosen small enough that most shots wrap at least once. The done and idle checks assume that arm is only sampled when idle. The bench nevertheless sends an arm pulse in the middle of a shot, to confirm that this pulse changes nothing at the ports.

// File: rtl/acq_addr_gen.sv
module acq_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              smp_vld,
  input  logic              trig,
  input  logic [CNT_W-1:0]  pre_cnt,
  input  logic [CNT_W-1:0]  post_cnt,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [ADDR_W-1:0] buf_size,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_en,
  output logic [1:0]        wr_ch,
  output logic [ADDR_W-1:0] trig_pos,
  output logic              done
);

  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] GROUP = ADDR_W'(8);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_WAIT, S_POST} st_t;

  st_t               st;
  logic [ADDR_W-1:0] base_q, size_q, off, cur_g, last_g, tp_off;
  logic [CNT_W-1:0]  pre_q, post_q, gcnt;
  logic [1:0]        ch;
  logic              pend, done_q;

  logic              at_bound, go_now, kill, grp_end;
  logic [ADDR_W-1:0] off_inc, off_nx;
  logic [CNT_W:0]    gcnt_inc;

  assign at_bound = (ch == 2'd0);
  assign go_now   = (st == S_WAIT) && (trig || pend) && at_bound;
  assign kill     = go_now && (post_q == '0);
  assign wr_en    = smp_vld && (st != S_IDLE) && !kill;
  assign grp_end  = wr_en && (ch == 2'd3);
  assign off_inc  = off + STEP;
  assign off_nx   = (off_inc == size_q) ? '0 : off_inc;
  assign gcnt_inc = {1'b0, gcnt} + 1'b1;

  assign wr_addr  = base_q + off;
  assign wr_ch    = ch;
  assign trig_pos = base_q + tp_off;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      size_q <= '0;
      pre_q  <= '0;
      post_q <= '0;
      off    <= '0;
      cur_g  <= '0;
      last_g <= '0;
      tp_off <= '0;
      gcnt   <= '0;
      ch     <= '0;
      pend   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        if (arm) begin
          base_q <= buf_base;
          size_q <= buf_size;
          pre_q  <= pre_cnt;
          post_q <= post_cnt;
          off    <= '0;
          ch     <= '0;
          gcnt   <= '0;
          pend   <= 1'b0;
          last_g <= buf_size - GROUP;
          st     <= (pre_cnt == '0) ? S_WAIT : S_PRE;
        end
      end else begin
        if (wr_en) begin
          off <= off_nx;
          ch  <= ch + 2'd1;
          if (at_bound) cur_g <= off;
        end
        if (grp_end) last_g <= cur_g;
        unique case (st)
          S_PRE: if (grp_end) begin
            gcnt <= gcnt + 1'b1;
            if (gcnt_inc >= {1'b0, pre_q}) st <= S_WAIT;
          end
          S_WAIT: begin
            if (go_now || (grp_end && (trig || pend))) begin
              tp_off <= go_now ? last_g : cur_g;
              gcnt   <= '0;
              pend   <= 1'b0;
              if (post_q == '0) begin
                st     <= S_IDLE;
                done_q <= 1'b1;
              end else begin
                st <= S_POST;
              end
            end else if (trig) begin
              pend <= 1'b1;
            end
          end
          S_POST: if (grp_end) begin
            gcnt <= gcnt + 1'b1;
            if (gcnt_inc == {1'b0, post_q}) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !wr_en);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ch_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_ch == $past(wr_ch) + 2'd1));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((wr_addr == $past(wr_addr) + STEP) || (wr_addr == base_q)));

  p_group_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ch == 2'd0) |-> ((wr_addr - base_q) % GROUP == '0));

  p_no_early_post_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE) |=> (st != S_POST));

endmodule

// File: tb/acq_addr_gen_tb.sv
module acq_addr_gen_tb;
  localparam int AW = 16;
  localparam int CW = 12;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, smp_vld = 1'b0, trig = 1'b0;
  logic [CW-1:0] pre_cnt = '0, post_cnt = '0;
  logic [AW-1:0] buf_base = '0, buf_size = '0;
  logic [AW-1:0] wr_addr, trig_pos;
  logic wr_en, done;
  logic [1:0] wr_ch;

  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acq_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_vld(smp_vld), .trig(trig),
    .pre_cnt(pre_cnt), .post_cnt(post_cnt), .buf_base(buf_base),
    .buf_size(buf_size), .wr_addr(wr_addr), .wr_en(wr_en), .wr_ch(wr_ch),
    .trig_pos(trig_pos), .done(done));

  typedef struct packed {
    logic [7:0]  pre;
    logic [7:0]  post;
    logic [15:0] base;
    logic [15:0] size;
    logic [15:0] trig_w;
    logic        gap;
    logic        early;
    logic        rearm;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd2, 8'd3, 16'h0100, 16'd32, 16'd8,  1'b0, 1'b0, 1'b0},
    '{8'd0, 8'd2, 16'h2000, 16'd48, 16'd0,  1'b0, 1'b0, 1'b0},
    '{8'd1, 8'd1, 16'h0040, 16'd16, 16'd12, 1'b1, 1'b0, 1'b0},
    '{8'd2, 8'd2, 16'h0000, 16'd24, 16'd9,  1'b0, 1'b0, 1'b0},
    '{8'd3, 8'd0, 16'h0300, 16'd64, 16'd16, 1'b0, 1'b1, 1'b0},
    '{8'd2, 8'd4, 16'h0800, 16'd40, 16'd8,  1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_shot(input vec_t v);
    int w = 0, total, n, tp, lastw_cyc = -10, k = 0;
    bit trig_sent = 0, seen_done = 0;
    n = int'(v.trig_w) / 4;
    if (v.trig_w % 4 == 0) begin
      total = 4 * (n + int'(v.post));
      tp = (n == 0) ? int'(v.base) + int'(v.size) - 8
                    : int'(v.base) + (8 * (n - 1)) % int'(v.size);
    end else begin
      total = 4 * (n + 1 + int'(v.post));
      tp = int'(v.base) + (8 * n) % int'(v.size);
    end
    @(negedge clk);
    arm = 1; pre_cnt = CW'(v.pre); post_cnt = CW'(v.post);
    buf_base = v.base; buf_size = v.size; smp_vld = 0; trig = 0;
    @(negedge clk);
    arm = 0; buf_base = 16'hF000; buf_size = 16'd8; pre_cnt = '0; post_cnt = '0;
    while (!seen_done && k < 2000) begin
      smp_vld = v.gap ? (k % 3 != 2) : 1'b1;
      trig = 0;
      arm = v.rearm && (w == 5);
      if (v.early && w == 1) trig = 1;
      if (!trig_sent && w == int'(v.trig_w)) begin trig = 1; trig_sent = 1; end
      #1;
      if (done) begin
        seen_done = 1;
        // R7: exact post count, done right after the last write
        chk(w == total, "R7 write count", w, total);
        if (v.post != 0) chk(cyc == lastw_cyc + 1, "R7 done timing", cyc, lastw_cyc + 1);
        // R5/R6: captured trigger position
        chk(trig_pos == AW'(tp), (v.trig_w % 4 == 0) ? "R5 trig_pos" : "R6 trig_pos",
            int'(trig_pos), tp);
      end
      if (wr_en) begin
        // R1/R2: byte stepping by 2 with wrap; R8: re-arm has no effect
        chk(wr_addr == AW'(int'(v.base) + (2 * w) % int'(v.size)),
            v.rearm ? "R8 addr" : "R2 addr", int'(wr_addr),
            int'(v.base) + (2 * w) % int'(v.size));
        chk(wr_ch == 2'(w % 4), "R1 channel", int'(wr_ch), w % 4);
        w++;
        lastw_cyc = cyc;
      end
      @(negedge clk);
      k++;
    end
    trig = 0; arm = 0;
    chk(seen_done, "R7 done seen", int'(seen_done), 1);
    // R4: an early pulse must not end the pre-trigger phase
    if (v.early) chk(w == total, "R4 early trigger ignored", w, total);
    smp_vld = 1;
    #1;
    chk(!done, "R7 done single cycle", int'(done), 0);
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(!wr_en, "R3 no writes after done", int'(wr_en), 0);
      @(negedge clk);
    end
    smp_vld = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    smp_vld = 1;
    #1;
    chk(!wr_en, "R9 reset wr_en", int'(wr_en), 0);
    chk(!done, "R9 reset done", int'(done), 0);
    chk(trig_pos == '0, "R9 reset trig_pos", int'(trig_pos), 0);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(!wr_en, "R3 no writes before arm", int'(wr_en), 0);
      @(negedge clk);
    end
    smp_vld = 0;
    for (int i = 0; i < 6; i++) run_shot(VECS[i]);
    // directed corner: zero pre, zero post, immediate trigger
    run_shot('{8'd0, 8'd0, 16'h0010, 16'd8, 16'd0, 1'b0, 1'b0, 1'b0});
    // directed corner: one-group region, wrap on every group
    run_shot('{8'd1, 8'd2, 16'h0500, 16'd8, 16'd4, 1'b1, 1'b0, 1'b1});
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule